// File: doc/BRIEF.md
# Self-Selecting Wired-OR Bus Arbiter

This block settles which of several contenders gets the bus without any central priority logic. Each contender cell has a fixed, unique, nonzero identifier of `ID_W` bits. Every cell drives a pattern onto a set of shared arbitration lines, and the lines carry the bitwise OR of all those patterns. There is also a start line. A cell raises the start line to open a round and puts its identifier on the lines. On every clock it compares the line value with its own identifier, working from the most significant bit down. It withdraws every bit at and below the first position where the lines hold a 1 and its identifier holds a 0.

The lines converge on the largest identifier in the round. A small line monitor watches the shared lines. When the value has stayed the same across one full clock boundary, the round is settled. At that point the cell whose identifier equals the line value raises `won` and holds the bus until it drops its request. Losers stop driving. The round then closes, and contenders that are still waiting open the next one.

Top module: `idsel_arbiter`

## Requirements
- R1: When no round is open and at least one `req` bit is high at a clock edge, a round opens at that edge: `round_busy` reads 1 after it, and every cell whose `req` was high at that edge takes part.
- R2: `arb_lines` is the bitwise OR of all cell drives. After the opening edge it equals the OR of the identifiers of all participants, for example 5 and 6 give 4'b0111.
- R3: A settled round grants the participant with the largest identifier: 5 and 6 grant the cell holding 6, and 5, 6, 9 and 12 grant the cell holding 12. While a cell's `won` is high, `arb_lines` equals that cell's identifier.
- R4: `won` rises only after `arb_lines` has kept one value across a full cycle. With 5 and 6, `won` is visible after the 4th edge counting the opening edge. With a single contender it is visible after the 3rd edge. Without dropouts the round never needs more than `ID_W`+3 edges.
- R5: At most one `won` bit is high at any time.
- R6: A cell whose `req` rises while a round is open does not take part in that round and never affects `arb_lines` in it. It contends in the next round, which opens one cycle after the current round closes.
- R7: A cell with `req` low drives all zeros and never asserts `won`. A participant that drops `req` during arbitration leaves the round, and the rest resolve among themselves: with 5, 6, 9 and 12 and cell 12 leaving after the opening edge, the lines read 4'b1000, then 4'b1001, and the cell holding 9 wins after the 5th edge.
- R8: `won` stays high while its `req` stays high. One edge after the winner drops `req`, `won` and `arb_lines` are 0. After one more edge `round_busy` is 0.
- R9: Synchronous active-high `rst` clears `won`, `arb_lines`, `start_line` and `round_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_CELLS | Per-cell bus request |
| cell_id | input | N_CELLS*ID_W | Packed identifiers, cell k at bits [k*ID_W +: ID_W]; unique, nonzero, held constant |
| won | output | N_CELLS | Per-cell grant, registered |
| arb_lines | output | ID_W | Shared arbitration line value (OR of cell drives) |
| start_line | output | 1 | Shared start-arbitration line (OR of cell start drives) |
| round_busy | output | 1 | A round is open (arbitrating or held by a winner) |

## Verification
The hardest situation to reach is a participant leaving after the others have already withdrawn low bits because of its presence. The remaining leader must then put back bits it had zeroed, and the line must re-settle on a value it never showed before. The bench reaches this by raising four requests together and dropping the largest identifier on the falling edge right after the opening edge. The first back-off step is then computed without that cell. The bench follows the line value 1111, 1000, 1001 and checks that the grant is deferred by exactly the extra settling cycle.

// File: rtl/idsel_pkg.sv
package idsel_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARB  = 2'd1,
    PH_HOLD = 2'd2
  } phase_e;
endpackage

// File: rtl/idsel_wor_merge.sv
module idsel_wor_merge #(
  parameter int N_CELLS = 4,
  parameter int ID_W    = 4
) (
  input  logic [N_CELLS-1:0][ID_W-1:0] drv,
  input  logic [N_CELLS-1:0]           start_drv,
  output logic [ID_W-1:0]              lines,
  output logic                         start_line
);
  always_comb begin
    lines = '0;
    for (int k = 0; k < N_CELLS; k++) begin
      lines = lines | drv[k];
    end
  end

  assign start_line = |start_drv;
endmodule

// File: rtl/idsel_round_mon.sv
module idsel_round_mon
  import idsel_pkg::*;
#(
  parameter int N_CELLS = 4,
  parameter int ID_W    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_line,
  input  logic [ID_W-1:0] lines,
  output phase_e          phase,
  output logic            settle,
  output logic            busy
);
  // worst case: every cell leaves once, each exit restarting a full settle
  localparam int ARB_LIMIT = (N_CELLS + 1) * (ID_W + 2);
  localparam int CNT_W     = $clog2(ARB_LIMIT + 1);

  phase_e          state_q, state_d;
  logic [ID_W-1:0] prev_q;
  logic [CNT_W-1:0] arb_cnt_q;

  assign settle = (state_q == PH_ARB) && (lines == prev_q);
  assign phase  = state_q;
  assign busy   = (state_q != PH_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_IDLE: if (start_line) state_d = PH_ARB;
      PH_ARB:  if (settle) state_d = (lines == '0) ? PH_IDLE : PH_HOLD;
      PH_HOLD: if (lines == '0) state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PH_IDLE;
      prev_q    <= '0;
      arb_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      prev_q  <= (state_q == PH_ARB) ? lines : '0;
      if (state_q == PH_ARB)
        arb_cnt_q <= (arb_cnt_q == CNT_W'(ARB_LIMIT)) ? arb_cnt_q : arb_cnt_q + 1'b1;
      else
        arb_cnt_q <= '0;
    end
  end

  // R4: arbitration always settles within the bounded window
  assert_settle_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_ARB) |-> (arb_cnt_q < CNT_W'(ARB_LIMIT)));

  // R8: the held line value does not move while a winner owns the bus
  assert_hold_line_steady_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_HOLD && $past(state_q == PH_HOLD) && lines != '0 && $past(lines) != '0)
      |-> (lines == $past(lines)));
endmodule

// File: rtl/idsel_cell.sv
module idsel_cell
  import idsel_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic [ID_W-1:0] my_id,
  input  phase_e          phase,
  input  logic            settle,
  input  logic [ID_W-1:0] lines,
  output logic [ID_W-1:0] drive,
  output logic            start_drv,
  output logic            won
);
  logic            part_q;
  logic [ID_W-1:0] drive_q;
  logic            won_q;
  logic [ID_W-1:0] cand;
  logic            knock;
  logic            active;
  logic            win_now;

  // back off below the first bit where someone else shows a 1 we lack
  always_comb begin
    knock = 1'b0;
    cand  = '0;
    for (int b = ID_W - 1; b >= 0; b--) begin
      if (lines[b] && !my_id[b]) knock = 1'b1;
      cand[b] = my_id[b] & ~knock;
    end
  end

  assign active    = part_q & req;
  assign win_now   = active && (lines == my_id);
  assign start_drv = (phase == PH_IDLE) ? req : active;

  always_ff @(posedge clk) begin
    if (rst) begin
      part_q  <= 1'b0;
      drive_q <= '0;
      won_q   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          part_q  <= req;
          drive_q <= req ? my_id : '0;
          won_q   <= 1'b0;
        end
        PH_ARB: begin
          part_q <= active;
          if (settle) begin
            won_q   <= win_now;
            drive_q <= win_now ? my_id : '0;
          end else begin
            won_q   <= 1'b0;
            drive_q <= active ? cand : '0;
          end
        end
        default: begin
          part_q  <= active;
          won_q   <= won_q & req;
          drive_q <= (won_q & req) ? my_id : '0;
        end
      endcase
    end
  end

  assign drive = drive_q;
  assign won   = won_q;

  // R3: a granted cell always sees its own identifier on the lines
  assert_won_matches_line_R3: assert property (@(posedge clk) disable iff (rst)
    won_q |-> (lines == my_id));

  // R8: dropping the request removes the grant at the next edge
  assert_drop_clears_won_R8: assert property (@(posedge clk) disable iff (rst)
    !req |=> !won_q);

  // R7: an idle request leaves the shared lines untouched by this cell
  assert_quiet_without_req_R7: assert property (@(posedge clk) disable iff (rst)
    !req |=> (drive_q == '0));

  // R6: participation can only begin while no round is open
  assert_join_only_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(part_q) |-> $past(phase == PH_IDLE));
endmodule

// File: rtl/idsel_arbiter.sv
module idsel_arbiter
  import idsel_pkg::*;
#(
  parameter int N_CELLS = 4,
  parameter int ID_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_CELLS-1:0]        req,
  input  logic [N_CELLS*ID_W-1:0]   cell_id,
  output logic [N_CELLS-1:0]        won,
  output logic [ID_W-1:0]           arb_lines,
  output logic                      start_line,
  output logic                      round_busy
);
  logic [N_CELLS-1:0][ID_W-1:0] drv_bus;
  logic [N_CELLS-1:0]           start_bus;
  logic [ID_W-1:0]              lines_w;
  logic                         start_w;
  phase_e                       phase_w;
  logic                         settle_w;
  logic                         busy_w;

  idsel_wor_merge #(.N_CELLS(N_CELLS), .ID_W(ID_W)) merge_i (
    .drv        (drv_bus),
    .start_drv  (start_bus),
    .lines      (lines_w),
    .start_line (start_w)
  );

  idsel_round_mon #(.N_CELLS(N_CELLS), .ID_W(ID_W)) mon_i (
    .clk        (clk),
    .rst        (rst),
    .start_line (start_w),
    .lines      (lines_w),
    .phase      (phase_w),
    .settle     (settle_w),
    .busy       (busy_w)
  );

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    idsel_cell #(.ID_W(ID_W)) cell_i (
      .clk       (clk),
      .rst       (rst),
      .req       (req[g]),
      .my_id     (cell_id[g*ID_W +: ID_W]),
      .phase     (phase_w),
      .settle    (settle_w),
      .lines     (lines_w),
      .drive     (drv_bus[g]),
      .start_drv (start_bus[g]),
      .won       (won[g])
    );
  end

  assign arb_lines  = lines_w;
  assign start_line = start_w;
  assign round_busy = busy_w;

  // R5: never more than one grant
  assert_single_grant_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(won));

  // R9: reset leaves no grant, no line activity and no open round
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (won == '0 && arb_lines == '0 && !round_busy));
endmodule

// File: tb/idsel_arbiter_tb_top.sv
module idsel_arbiter_tb_top;
  localparam int N  = 4;
  localparam int IW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    req = '0;
  logic [N*IW-1:0] cell_id = {4'd12, 4'd9, 4'd6, 4'd5};
  logic [N-1:0]    won;
  logic [IW-1:0]   arb_lines;
  logic            start_line;
  logic            round_busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  idsel_arbiter #(.N_CELLS(N), .ID_W(IW)) dut_i (
    .clk(clk), .rst(rst), .req(req), .cell_id(cell_id),
    .won(won), .arb_lines(arb_lines), .start_line(start_line), .round_busy(round_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic release_all();
    req = '0;
    tick(); tick(); tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; req = '0;
    tick(); tick(); tick();
    rst = 1'b0;
    chk("R9 won after reset", 32'(won), 0);
    chk("R9 lines after reset", 32'(arb_lines), 0);
    chk("R9 busy after reset", 32'(round_busy), 0);
    chk("R9 start after reset", 32'(start_line), 0);
  endtask

  task automatic t_pair();
    req = 4'b0011;
    tick();
    chk("R1 busy after open", 32'(round_busy), 1);
    chk("R2 OR of 5 and 6", 32'(arb_lines), 32'h7);
    chk("R4 no early won e1", 32'(won), 0);
    tick();
    chk("R3 backoff line", 32'(arb_lines), 32'h6);
    chk("R4 no early won e2", 32'(won), 0);
    tick();
    chk("R4 no won before stable cycle", 32'(won), 0);
    tick();
    chk("R3 R4 id 6 wins at edge 4", 32'(won), 32'b0010);
    chk("R3 line equals winner", 32'(arb_lines), 32'h6);
    tick();
    chk("R8 won held", 32'(won), 32'b0010);
    req = '0;
    tick();
    chk("R8 won cleared", 32'(won), 0);
    chk("R8 lines cleared", 32'(arb_lines), 0);
    tick();
    chk("R8 round closed", 32'(round_busy), 0);
  endtask

  task automatic t_single();
    req = 4'b0100;
    tick();
    chk("R2 single line", 32'(arb_lines), 32'h9);
    tick();
    chk("R4 single no early won", 32'(won), 0);
    tick();
    chk("R4 single won at edge 3", 32'(won), 32'b0100);
    release_all();
  endtask

  task automatic t_all();
    req = 4'b1111;
    tick();
    chk("R2 OR of all", 32'(arb_lines), 32'hF);
    tick();
    chk("R3 all backoff", 32'(arb_lines), 32'hC);
    tick();
    chk("R4 all no early won", 32'(won), 0);
    tick();
    chk("R3 id 12 wins", 32'(won), 32'b1000);
    chk("R5 one grant", 32'($countones(won)), 1);
    release_all();
  endtask

  task automatic t_drop();
    req = 4'b1111;
    tick();
    chk("R7 drop start line", 32'(arb_lines), 32'hF);
    req[3] = 1'b0;
    tick();
    chk("R7 after drop", 32'(arb_lines), 32'h8);
    tick();
    chk("R7 bits restored", 32'(arb_lines), 32'h9);
    tick();
    chk("R7 no won while resettling", 32'(won), 0);
    tick();
    chk("R7 id 9 wins after drop", 32'(won), 32'b0100);
    chk("R7 dropped cell not granted", 32'(won[3]), 0);
    release_all();
  endtask

  task automatic t_late();
    int waited = 0;
    req = 4'b0001;
    tick();
    req[3] = 1'b1;
    tick();
    chk("R6 late cell off lines", 32'(arb_lines), 32'h5);
    tick();
    chk("R6 early cell wins", 32'(won), 32'b0001);
    chk("R6 line unaffected", 32'(arb_lines), 32'h5);
    tick();
    chk("R7 idle cell never wins", 32'(won[1]), 0);
    req[0] = 1'b0;
    tick();
    chk("R8 release clears", 32'(won), 0);
    tick();
    chk("R8 busy low after release", 32'(round_busy), 0);
    tick();
    chk("R6 next round opens", 32'(arb_lines), 32'hC);
    while (won[3] !== 1'b1 && waited < 10) begin
      tick();
      waited++;
    end
    chk("R6 late cell wins next round", 32'(won), 32'b1000);
    chk("R4 late round latency", 32'(waited), 2);
    release_all();
  endtask

  initial begin
    t_reset();
    t_pair();
    t_single();
    t_all();
    t_drop();
    t_late();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule